// File: doc/BRIEF.md
# Banked Data Memory Address Decoder

This block sits between the operand path of a small 8-bit core and its data memory. Each access carries a 7-bit direct address taken from the instruction, together with the bank-select bit supplied by the core's status register. From these the block forms an 8-bit effective register address and sends the access to one of five targets. These are the external special-function register block, a local 64-byte general-purpose RAM, the local file-pointer register, an unimplemented hole, or a null target. The null target is reached when indirection lands on the indirection address itself.

A direct address of zero means the access is indirect. The effective address is then the full 8-bit file pointer, and bit 7 of the pointer picks the bank. The RAM occupies the same low-address window in both banks, so bank 1 sees the same physical bytes as bank 0. The file pointer lives here and is not forwarded to the external register block. Every other special-function address is forwarded with its full bank-qualified address. Reads are combinational. Writes take effect at the rising clock edge.

Top module: `dmem_front`

## Requirements
- R1: A direct access (dir_addr not 0) uses effective address {bank_sel, dir_addr}. Bit 7 is the bank, so the same dir_addr reaches different special-function addresses in bank 0 and bank 1.
- R2: When dir_addr is 0 the access is indirect. The effective address is the 8-bit pointer value, and pointer bit 7 selects the bank.
- R3: Effective addresses whose low 7 bits lie in 0x20..0x5F reach RAM byte (low7 - 0x20). Bank 0 and bank 1 reach the same byte. A write lands at the rising edge, and the read data follows the address in the same cycle.
- R4: Low 7 bits in 0x60..0x7F form a hole. Reads return 0, writes change no RAM byte and no pointer value, and sfr_sel stays low.
- R5: Low 7 bits in 0x01..0x1F, other than 0x04, go to the external block. sfr_sel is high, sfr_addr is the 8-bit effective address, sfr_we follows acc_we, sfr_wdata follows wr_data, and rd_data returns sfr_rdata.
- R6: Low 7 bits equal to 0x04, in either bank, address the local pointer. Reads return it, a write loads it at the rising edge, and sfr_sel stays low. An indirect write whose pointer selects the pointer itself reloads the pointer.
- R7: An indirect access whose effective address has low 7 bits 0 reads 0, writes nothing, and keeps sfr_sel low.
- R8: After reset the pointer is 0.
- R9: With acc_en low, rd_data is 0, sfr_sel and sfr_we are low, and no RAM byte or pointer changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_en | input | 1 | Access valid this cycle |
| acc_we | input | 1 | Access is a write |
| dir_addr | input | 7 | Direct address field from the instruction |
| bank_sel | input | 1 | Bank-select bit from the status register |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data, combinational |
| sfr_sel | output | 1 | External special-function register selected |
| sfr_we | output | 1 | Write strobe to the external block |
| sfr_addr | output | 8 | Bank-qualified effective address to the external block |
| sfr_wdata | output | 8 | Write data to the external block |
| sfr_rdata | input | 8 | Read data from the external block |

## Verification
Two functions can fall in one cycle: the pointer supplies the address, and the same access writes the pointer. This happens when the pointer holds 0x04 or 0x84 and an indirect access is made. The bench provokes it directly. It judges that the indirect read in that cycle returns the old pointer, and that a write makes the next indirect access use the newly written pointer. The bench also sweeps all 256 pointer values against direct reads of the same location, and checks that the RAM image is unchanged after hole, null and idle writes.

// File: rtl/dmem_front_pkg.sv
package dmem_front_pkg;

  typedef enum logic [2:0] {
    RG_SFR  = 3'd0,
    RG_GPR  = 3'd1,
    RG_HOLE = 3'd2,
    RG_PTR  = 3'd3,
    RG_NULL = 3'd4
  } region_e;

  // Sort the in-bank offset of an effective address into a target region.
  function automatic region_e classify(input int unsigned low,
                                       input int unsigned sfr_span,
                                       input int unsigned gpr_base,
                                       input int unsigned gpr_depth,
                                       input int unsigned ptr_loc);
    region_e r;
    if (low == 0)                              r = RG_NULL;
    else if (low == ptr_loc)                   r = RG_PTR;
    else if (low < sfr_span)                   r = RG_SFR;
    else if (low >= gpr_base &&
             low <  gpr_base + gpr_depth)      r = RG_GPR;
    else                                       r = RG_HOLE;
    return r;
  endfunction

  // RAM byte number for an in-bank offset inside the RAM window.
  function automatic int unsigned gpr_offset(input int unsigned low,
                                             input int unsigned gpr_base);
    return low - gpr_base;
  endfunction

endpackage

// File: rtl/dmem_addr_gen.sv
module dmem_addr_gen #(
  parameter int DIR_W = 7,
  localparam int EA_W = DIR_W + 1
) (
  input  logic [DIR_W-1:0] dir_addr,
  input  logic             bank_sel,
  input  logic [EA_W-1:0]  ptr_val,
  output logic [EA_W-1:0]  eff_addr,
  output logic             ind_mode
);

  // A zero direct field names the indirection slot.
  assign ind_mode = (dir_addr == '0);
  assign eff_addr = ind_mode ? ptr_val : {bank_sel, dir_addr};

endmodule

// File: rtl/dmem_region_dec.sv
module dmem_region_dec
  import dmem_front_pkg::*;
#(
  parameter int DIR_W     = 7,
  parameter int SFR_SPAN  = 32,
  parameter int GPR_BASE  = 32,
  parameter int GPR_DEPTH = 64,
  parameter int PTR_LOC   = 4,
  localparam int IDX_W    = $clog2(GPR_DEPTH)
) (
  input  logic [DIR_W-1:0] low_addr,
  output region_e          region,
  output logic [IDX_W-1:0] gpr_idx
);

  int unsigned low_u;
  int unsigned off_u;

  always_comb begin
    low_u   = int'(low_addr);
    region  = classify(low_u, SFR_SPAN, GPR_BASE, GPR_DEPTH, PTR_LOC);
    off_u   = gpr_offset(low_u, GPR_BASE);
    gpr_idx = off_u[IDX_W-1:0];
  end

endmodule

// File: rtl/dmem_gpr_ram.sv
module dmem_gpr_ram #(
  parameter int DEPTH  = 64,
  parameter int DATA_W = 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) cells[idx] <= wdata;
  end

  assign rdata = cells[idx];

endmodule

// File: rtl/dmem_front.sv
module dmem_front
  import dmem_front_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int DIR_W     = 7,
  parameter int SFR_SPAN  = 32,
  parameter int GPR_BASE  = 32,
  parameter int GPR_DEPTH = 64,
  parameter int PTR_LOC   = 4,
  localparam int EA_W     = DIR_W + 1,
  localparam int IDX_W    = $clog2(GPR_DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_en,
  input  logic              acc_we,
  input  logic [DIR_W-1:0]  dir_addr,
  input  logic              bank_sel,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              sfr_sel,
  output logic              sfr_we,
  output logic [EA_W-1:0]   sfr_addr,
  output logic [DATA_W-1:0] sfr_wdata,
  input  logic [DATA_W-1:0] sfr_rdata
);

  // Named internal events, observed by the bound checker.
  logic [EA_W-1:0]   ptr_q;
  logic [EA_W-1:0]   eff_addr;
  logic              ind_mode;
  region_e           region;
  logic [IDX_W-1:0]  gpr_idx;
  logic              hit_sfr, hit_gpr, hit_hole, hit_ptr, hit_null;
  logic              gpr_wr, ptr_wr;
  logic [DATA_W-1:0] gpr_rd;

  dmem_addr_gen #(.DIR_W(DIR_W)) u_addr (
    .dir_addr (dir_addr),
    .bank_sel (bank_sel),
    .ptr_val  (ptr_q),
    .eff_addr (eff_addr),
    .ind_mode (ind_mode)
  );

  dmem_region_dec #(
    .DIR_W(DIR_W), .SFR_SPAN(SFR_SPAN), .GPR_BASE(GPR_BASE),
    .GPR_DEPTH(GPR_DEPTH), .PTR_LOC(PTR_LOC)
  ) u_dec (
    .low_addr (eff_addr[DIR_W-1:0]),
    .region   (region),
    .gpr_idx  (gpr_idx)
  );

  assign hit_sfr  = acc_en && (region == RG_SFR);
  assign hit_gpr  = acc_en && (region == RG_GPR);
  assign hit_hole = acc_en && (region == RG_HOLE);
  assign hit_ptr  = acc_en && (region == RG_PTR);
  assign hit_null = acc_en && (region == RG_NULL);

  assign gpr_wr = hit_gpr && acc_we;
  assign ptr_wr = hit_ptr && acc_we;

  dmem_gpr_ram #(.DEPTH(GPR_DEPTH), .DATA_W(DATA_W)) u_ram (
    .clk   (clk),
    .wr_en (gpr_wr),
    .idx   (gpr_idx),
    .wdata (wr_data),
    .rdata (gpr_rd)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_q <= '0;
    else if (ptr_wr) ptr_q <= wr_data[EA_W-1:0];
  end

  assign sfr_sel   = hit_sfr;
  assign sfr_we    = hit_sfr && acc_we;
  assign sfr_addr  = eff_addr;
  assign sfr_wdata = wr_data;

  always_comb begin
    rd_data = '0;
    if (hit_sfr)      rd_data = sfr_rdata;
    else if (hit_gpr) rd_data = gpr_rd;
    else if (hit_ptr) rd_data = DATA_W'(ptr_q);
  end

endmodule

// File: rtl/dmem_front_chk.sv
module dmem_front_chk #(
  parameter int DATA_W = 8,
  parameter int DIR_W  = 7,
  localparam int EA_W  = DIR_W + 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              acc_en,
  input logic              acc_we,
  input logic [DATA_W-1:0] wr_data,
  input logic [DATA_W-1:0] rd_data,
  input logic              sfr_sel,
  input logic              sfr_we,
  input logic [EA_W-1:0]   sfr_addr,
  input logic [EA_W-1:0]   eff_addr,
  input logic [EA_W-1:0]   ptr_q,
  input logic              hit_sfr,
  input logic              hit_hole,
  input logic              hit_ptr,
  input logic              hit_null
);

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_en |-> (!sfr_sel && !sfr_we && rd_data == '0));

  // R4
  hole_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_hole |-> (rd_data == '0 && !sfr_sel));

  // R7
  null_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_null |-> (rd_data == '0 && !sfr_sel));

  // R6
  ptr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_ptr && acc_we) |=> (ptr_q == $past(wr_data[EA_W-1:0])));

  // R6
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(hit_ptr && acc_we) |=> $stable(ptr_q));

  // R6
  ptr_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_ptr |-> (rd_data == DATA_W'(ptr_q) && !sfr_sel));

  // R5
  sfr_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_sfr |-> (sfr_sel && sfr_addr == eff_addr && sfr_we == acc_we));

endmodule

bind dmem_front dmem_front_chk #(.DATA_W(DATA_W), .DIR_W(DIR_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .acc_en   (acc_en),
  .acc_we   (acc_we),
  .wr_data  (wr_data),
  .rd_data  (rd_data),
  .sfr_sel  (sfr_sel),
  .sfr_we   (sfr_we),
  .sfr_addr (sfr_addr),
  .eff_addr (eff_addr),
  .ptr_q    (ptr_q),
  .hit_sfr  (hit_sfr),
  .hit_hole (hit_hole),
  .hit_ptr  (hit_ptr),
  .hit_null (hit_null)
);

// File: tb/dmem_front_bench.sv
module dmem_front_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       acc_en = 1'b0;
  logic       acc_we = 1'b0;
  logic [6:0] dir_addr = '0;
  logic       bank_sel = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       sfr_sel, sfr_we;
  logic [7:0] sfr_addr, sfr_wdata;
  logic [7:0] sfr_rdata = '0;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  logic [7:0] img [64];
  logic [7:0] ptr_m;

  always #2.5 clk = ~clk;

  dmem_front u_dmem_front (
    .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_we(acc_we),
    .dir_addr(dir_addr), .bank_sel(bank_sel), .wr_data(wr_data),
    .rd_data(rd_data), .sfr_sel(sfr_sel), .sfr_we(sfr_we),
    .sfr_addr(sfr_addr), .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive one access after the falling edge; outputs settle 1 time unit later.
  task automatic drive(input logic en, input logic we, input logic bank,
                       input logic [6:0] da, input logic [7:0] wd);
    @(negedge clk);
    acc_en = en; acc_we = we; bank_sel = bank; dir_addr = da; wr_data = wd;
    #1;
  endtask

  function automatic logic [7:0] pat(input int i, input int k);
    return 8'((i * 37 + k * 11 + 5) & 8'hFF);
  endfunction

  // Expected read value for an effective address, from the requirements.
  function automatic logic [7:0] exp_rd(input logic [7:0] ea);
    int low;
    low = int'(ea[6:0]);
    if (low == 0)      return 8'h00;
    else if (low == 4) return ptr_m;
    else if (low < 32) return sfr_rdata;
    else if (low < 96) return img[low - 32];
    else               return 8'h00;
  endfunction

  task automatic sweep_ram(input string req, input logic bank);
    for (int i = 0; i < 64; i++) begin
      drive(1'b1, 1'b0, bank, 7'(32 + i), 8'h00);
      check(req, rd_data, img[i]);
    end
  endtask

  task automatic set_ptr(input logic [7:0] v);
    drive(1'b1, 1'b1, v[0], 7'd4, v);
    ptr_m = v;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_err++;
      n_chk++;
      $display("FAIL watchdog actual=%h expected=%h", 8'h01, 8'h00);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    ptr_m = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R8: pointer reads 0 after reset, in both banks
    drive(1'b1, 1'b0, 1'b0, 7'd4, 8'h00);
    check("R8", rd_data, 8'h00);
    drive(1'b1, 1'b0, 1'b1, 7'd4, 8'h00);
    check("R8", rd_data, 8'h00);

    // R3: fill RAM through bank 0, read it back through bank 1 and bank 0
    for (int i = 0; i < 64; i++) begin
      drive(1'b1, 1'b1, 1'b0, 7'(32 + i), pat(i, 0));
      img[i] = pat(i, 0);
    end
    sweep_ram("R3", 1'b1);
    // R3: overwrite through bank 1, read back through bank 0
    for (int i = 0; i < 64; i += 3) begin
      drive(1'b1, 1'b1, 1'b1, 7'(32 + i), pat(i, 1));
      img[i] = pat(i, 1);
    end
    sweep_ram("R3", 1'b0);

    // R4: hole writes in both banks read 0, leave RAM alone
    for (int b = 0; b < 2; b++) begin
      for (int a = 96; a < 128; a++) begin
        drive(1'b1, 1'b1, b[0], 7'(a), 8'hFF);
        check("R4", {7'b0, sfr_sel}, 8'h00);
        check("R4", rd_data, 8'h00);
      end
    end
    sweep_ram("R4", 1'b0);
    drive(1'b1, 1'b0, 1'b0, 7'd4, 8'h00);
    check("R4", rd_data, ptr_m);

    // R5 and R1: forwarding to the external block, both banks
    for (int b = 0; b < 2; b++) begin
      for (int a = 1; a < 32; a++) begin
        if (a != 4) begin
          sfr_rdata = 8'(a * 5 + b * 128);
          drive(1'b1, b[0], b[0], 7'(a), 8'(a ^ 8'h5A));
          check("R5", {7'b0, sfr_sel}, 8'h01);
          check("R5", {7'b0, sfr_we}, {7'b0, b[0]});
          check("R1", sfr_addr, {b[0], 7'(a)});
          check("R5", sfr_wdata, 8'(a ^ 8'h5A));
          check("R5", rd_data, 8'(a * 5 + b * 128));
        end
      end
    end
    sfr_rdata = 8'hC3;

    // R6: pointer written in bank 1, read in bank 0, not forwarded
    set_ptr(8'hA5);
    check("R6", {7'b0, sfr_sel}, 8'h00);
    drive(1'b1, 1'b0, 1'b0, 7'd4, 8'h00);
    check("R6", rd_data, 8'hA5);

    // R2: indirect read for every pointer value against the model
    for (int v = 0; v < 256; v++) begin
      set_ptr(8'(v));
      drive(1'b1, 1'b0, 1'b0, 7'd0, 8'h00);
      check("R2", rd_data, exp_rd(8'(v)));
      if (v[6:0] > 0 && v[6:0] < 32 && v[6:0] != 4)
        check("R2", sfr_addr, 8'(v));
    end

    // R2: indirect writes through bank-1 pointers land in the shared RAM
    for (int i = 0; i < 64; i += 5) begin
      set_ptr(8'(128 + 32 + i));
      drive(1'b1, 1'b1, 1'b0, 7'd0, pat(i, 2));
      img[i] = pat(i, 2);
    end
    sweep_ram("R2", 1'b0);

    // R7: indirect access to the indirection slot in both banks
    for (int b = 0; b < 2; b++) begin
      set_ptr(8'(b * 128));
      drive(1'b1, 1'b1, 1'b1, 7'd0, 8'h55);
      check("R7", rd_data, 8'h00);
      check("R7", {7'b0, sfr_sel}, 8'h00);
    end
    sweep_ram("R7", 1'b1);
    drive(1'b1, 1'b0, 1'b0, 7'd4, 8'h00);
    check("R7", rd_data, 8'h80);

    // R6: the pointer addresses itself; read gives old value, write reloads it
    set_ptr(8'h84);
    drive(1'b1, 1'b0, 1'b0, 7'd0, 8'h00);
    check("R6", rd_data, 8'h84);
    drive(1'b1, 1'b1, 1'b0, 7'd0, 8'h33);
    check("R6", rd_data, 8'h84);
    ptr_m = 8'h33;
    drive(1'b1, 1'b0, 1'b0, 7'd0, 8'h00);
    check("R6", rd_data, img[8'h33 - 32]);
    drive(1'b1, 1'b0, 1'b1, 7'd4, 8'h00);
    check("R6", rd_data, 8'h33);

    // R9: idle cycles with write asserted touch nothing
    drive(1'b0, 1'b1, 1'b0, 7'd40, 8'hEE);
    check("R9", rd_data, 8'h00);
    check("R9", {6'b0, sfr_sel, sfr_we}, 8'h00);
    drive(1'b0, 1'b1, 1'b0, 7'd4, 8'hEE);
    drive(1'b0, 1'b1, 1'b1, 7'd10, 8'hEE);
    check("R9", {6'b0, sfr_sel, sfr_we}, 8'h00);
    sweep_ram("R9", 1'b0);
    drive(1'b1, 1'b0, 1'b0, 7'd4, 8'h00);
    check("R9", rd_data, 8'h33);

    drive(1'b0, 1'b0, 1'b0, 7'd0, 8'h00);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule